// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between an internal request port and an external asynchronous static RAM of 256K words by 4 bits. A requester offers one read or one write at a time over a valid/ready handshake. The controller then presents the address and drives the active-low chip-select, output-gate and write strobes. Each strobe phase is held for a whole number of system-clock cycles, derived at elaboration from the clock period and the memory's minimum timing figures. Read data comes back registered, together with a one-cycle response pulse.

The data pins are split into an outgoing word, an incoming word and a driver enable, so the pad ring can build the bidirectional bus. The controller turns its drivers on only while the write strobe is low. Every strobe phase is followed by at least one cycle with all strobes released. That cycle gives the memory time to float its outputs before the bus changes direction. It also forces a fresh write-strobe edge for every write.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the chip-select, output-gate and write strobes are high, the driver enable is low, the response pulse is low and request-ready is high.
- R2: Request-ready is high only while the controller is idle. A request is taken on a clock edge where request-valid and request-ready are both high. While a transaction is in progress, changes on the request inputs have no effect on the memory pins. The write flag is 1 for a write and 0 for a read.
- R3: A read holds chip-select low, output-gate low, write strobe high and driver enable low for exactly RD = max(1, ceil(T_AA_NS / T_CLK_NS)) consecutive cycles.
- R4: The memory's data is registered on the clock edge that ends the read phase. The response pulse is high for exactly that one following cycle, which is RD+1 cycles after the accepting edge. The returned data stays unchanged until the next read completes.
- R5: A write holds chip-select low, write strobe low, output-gate high and driver enable high for exactly WR = max(1, ceil(max(T_WP_NS, T_DW_NS) / T_CLK_NS)) consecutive cycles.
- R6: The address, and for a write the outgoing data, appear on the pins in the same cycle that chip-select falls. They stay unchanged for as long as chip-select stays low.
- R7: The data drivers are enabled only while the write strobe is low, and never while the output gate is low.
- R8: Two strobe phases are always separated by at least one cycle with all strobes high, so a read never follows a write without that turnaround. When the next request is offered in the first idle cycle, the separation is exactly one cycle. A phase never changes between read and write while chip-select stays low.
- R9: A write produces no response pulse.
- R10: The memory pins carry the address and write data of the accepted request. A read returns the word last written at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_ce_n | output | 1 | Chip-select strobe, active low |
| mem_oe_n | output | 1 | Output-gate strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
Two events share one clock edge. The read data is sampled from the memory, and on that same edge chip-select and the output gate rise and the controller becomes idle again. The memory model returns the stored word only from the last cycle of the access window and returns zero before that. A capture made one cycle early, or made after the strobes have been released, therefore returns a wrong word. The second overlap is between a write's release and an immediately following read. Here the bench checks that exactly one all-high cycle separates them, and that the read returns the data just written.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  // Whole clock cycles covering t_ns, never fewer than one.
  function automatic int unsigned phase_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  // R3 R5: a non-zero load keeps the phase open for the next cycle
  long_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !done);

endmodule

// File: rtl/strobe_sequencer.sv
module strobe_sequencer
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW     = 2,
  parameter int unsigned RD_CYC = 1,
  parameter int unsigned WR_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          phase_done,
  output logic          req_ready,
  output logic          accept,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          capture,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

  seq_state_e state_q, state_d;
  logic ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          if (req_write) begin
            state_d = ST_WRITE;
            cnt_val = WR_LOAD;
          end else begin
            state_d = ST_READ;
            cnt_val = RD_LOAD;
          end
        end
      end
      ST_READ: begin
        if (phase_done) begin
          state_d = ST_IDLE;
          capture = 1'b1;
        end
      end
      ST_WRITE: begin
        if (phase_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobes are decoded from the next state and registered: no glitches on the pins.
  always_comb begin
    ce_n_d  = (state_d == ST_IDLE);
    oe_n_d  = (state_d != ST_READ);
    we_n_d  = (state_d != ST_WRITE);
    dq_oe_d = (state_d == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ce_n      = ce_n_q;
  assign oe_n      = oe_n_q;
  assign we_n      = we_n_q;
  assign dq_oe     = dq_oe_q;

  // R2
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n && we_n && !dq_oe));

  // R3 R5
  phase_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !phase_done) |=> (state_q == $past(state_q)));

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned T_CLK_NS = 20,
  parameter int unsigned T_AA_NS  = 15,
  parameter int unsigned T_WP_NS  = 12,
  parameter int unsigned T_DW_NS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned T_WR_NS = (T_WP_NS > T_DW_NS) ? T_WP_NS : T_DW_NS;
  localparam int unsigned RD_CYC  = phase_cycles(T_AA_NS, T_CLK_NS);
  localparam int unsigned WR_CYC  = phase_cycles(T_WR_NS, T_CLK_NS);
  localparam int unsigned MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic          accept, cnt_load, capture, phase_done;
  logic [CW-1:0] cnt_val;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  strobe_sequencer #(
    .CW     (CW),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_done (phase_done),
    .req_ready  (req_ready),
    .accept     (accept),
    .cnt_load   (cnt_load),
    .cnt_val    (cnt_val),
    .capture    (capture),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe)
  );

  phase_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (phase_done)
  );

  // Request capture: address and data move only when a request is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // Read return path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) begin
        rdata_q <= mem_dq_i;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;

  // R7
  driver_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  // R8
  no_mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_we_n) && $stable(mem_oe_n)));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && mem_ce_n));

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

  localparam int T_CLK = 20;
  localparam int T_AA  = 25;
  localparam int T_WP  = 35;
  localparam int T_DW  = 41;
  // Expected phase lengths from R3 / R5, computed here.
  localparam int RDC_RAW = (T_AA + T_CLK - 1) / T_CLK;
  localparam int WRT     = (T_WP > T_DW) ? T_WP : T_DW;
  localparam int WPC_RAW = (WRT + T_CLK - 1) / T_CLK;
  localparam int RDC     = (RDC_RAW < 1) ? 1 : RDC_RAW;
  localparam int WPC     = (WPC_RAW < 1) ? 1 : WPC_RAW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [3:0]  mem_dq_o, mem_dq_i;

  int total = 0;
  int bad = 0;
  int exp_gap = 0;
  logic [3:0] last_rd = 4'h0;

  always #(T_CLK / 2) clk = ~clk;

  sram_strobe_ctrl #(
    .ADDR_W(18), .DATA_W(4), .T_CLK_NS(T_CLK),
    .T_AA_NS(T_AA), .T_WP_NS(T_WP), .T_DW_NS(T_DW)
  ) i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model: 64 slots with a tag on the upper address bits; data only late in the access.
  logic [3:0]  mdat [64];
  logic [11:0] mtag [64];
  int          rcnt = 0;
  int          wcnt = 0;
  logic [17:0] wa = '0;
  logic [3:0]  wd = '0;

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && rcnt >= RDC - 1 &&
                     mtag[mem_addr[5:0]] == mem_addr[17:6]) ? mdat[mem_addr[5:0]] : 4'h0;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rcnt <= rcnt + 1;
    else rcnt <= 0;
    if (!mem_ce_n && !mem_we_n) begin
      wcnt <= wcnt + 1;
      wa   <= mem_addr;
      wd   <= mem_dq_o;
    end else if (wcnt != 0) begin
      mdat[wa[5:0]] <= wd;
      mtag[wa[5:0]] <= wa[17:6];
      wcnt <= 0;
    end
  end

  // Pin monitor, sampled mid-cycle.
  int          run = 0;
  int          gap = 0;
  logic        mode_wr = 1'b0;
  logic [17:0] a0 = '0;
  logic [3:0]  d0 = '0;
  logic        prev_rv = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(prev_rv && rsp_valid), "R4 pulse", int'(rsp_valid), 0);
      chk(!mem_dq_oe || (!mem_we_n && mem_oe_n), "R7", int'(mem_dq_oe), int'(!mem_we_n));
      if (!mem_ce_n) begin
        if (run == 0) begin
          mode_wr = !mem_we_n;
          a0 = mem_addr;
          d0 = mem_dq_o;
          if (exp_gap > 0) chk(gap == exp_gap, "R8 gap", gap, exp_gap);
          chk(gap >= 1, "R8 min gap", gap, 1);
          gap = 0;
        end else begin
          chk(mem_addr == a0, "R6 addr", int'(mem_addr), int'(a0));
          if (mode_wr) chk(mem_dq_o == d0, "R6 data", int'(mem_dq_o), int'(d0));
          chk(mode_wr == !mem_we_n, "R8 mode", int'(!mem_we_n), int'(mode_wr));
        end
        if (mode_wr) chk(mem_oe_n && mem_dq_oe, "R5 strobes", int'(mem_dq_oe), 1);
        else chk(!mem_oe_n && mem_we_n && !mem_dq_oe, "R3 strobes", int'(mem_oe_n), 0);
        run++;
      end else begin
        if (run > 0) begin
          if (mode_wr) chk(run == WPC, "R5 length", run, WPC);
          else chk(run == RDC, "R3 length", run, RDC);
        end
        chk(mem_oe_n && mem_we_n && !mem_dq_oe, "R8 released", int'(mem_dq_oe), 0);
        run = 0;
        gap++;
      end
      prev_rv = rsp_valid;
    end
  end

  function automatic logic [17:0] addr_of(input int k);
    logic [5:0] b;
    b = k[5:0];
    return {b, ~b, b};
  endfunction

  task automatic do_write(input logic [17:0] a, input logic [3:0] d, input int g);
    int n;
    exp_gap = g;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    // R2: wiggled inputs while busy must not reach the pins
    req_valid = 1'b0; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
    chk(mem_addr == a, "R10 addr", int'(mem_addr), int'(a));
    chk(mem_dq_o == d, "R10 wdata", int'(mem_dq_o), int'(d));
    n = 1;
    while (!req_ready) begin
      chk(!rsp_valid, "R9", int'(rsp_valid), 0);
      chk(rsp_rdata == last_rd, "R4 hold", int'(rsp_rdata), int'(last_rd));
      @(negedge clk);
      n++;
    end
    chk(!rsp_valid, "R9", int'(rsp_valid), 0);
    chk(n == WPC + 1, "R2 busy length", n, WPC + 1);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [3:0] e, input int g);
    int n;
    exp_gap = g;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 4'h0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b1; req_addr = ~a; req_wdata = 4'hF;
    chk(mem_addr == a, "R10 addr", int'(mem_addr), int'(a));
    n = 1;
    while (!rsp_valid) begin
      chk(!req_ready, "R2 ready low", int'(req_ready), 0);
      @(negedge clk);
      n++;
    end
    chk(n == RDC + 1, "R4 latency", n, RDC + 1);
    chk(rsp_rdata == e, "R10 read data", int'(rsp_rdata), int'(e));
    chk(req_ready && mem_ce_n, "R4 release", int'(mem_ce_n), 1);
    last_rd = e;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mdat[i] = 4'h0;
      mtag[i] = 12'hFFF;
    end
    repeat (3) @(negedge clk);
    // R1
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe && !rsp_valid, "R1 outputs", int'({mem_dq_oe, rsp_valid}), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && !mem_dq_oe && req_ready, "R1 after release", int'(mem_ce_n), 1);

    for (int k = 0; k < 64; k++) do_write(addr_of(k), 4'((k % 15) + 1), (k == 0) ? 0 : 1);
    for (int k = 0; k < 64; k++) do_read(addr_of(k), 4'((k % 15) + 1), 1);

    // R8: write immediately followed by a read of the same word
    for (int k = 0; k < 16; k++) begin
      do_write(addr_of(k * 3), 4'(15 - k), 1);
      do_read(addr_of(k * 3), 4'(15 - k), 1);
    end

    // R2: idle cycles with moving inputs and no valid leave the pins quiet
    for (int c = 0; c < 3; c++) begin
      req_write = c[0]; req_addr = addr_of(c + 7); req_wdata = 4'(c);
      @(negedge clk);
      chk(mem_ce_n && mem_addr == addr_of(45), "R2 idle", int'(mem_addr), int'(addr_of(45)));
    end
    do_read(addr_of(45), 4'(15 - 15), 4);

    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule